// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Controller

This block sits next to a floating-point datapath and owns the exception-related fields of a 32-bit FP status word. When an FP operation begins (`op_start`), the status word is loaded from `stat_in` with its current-exception and trap-type fields cleared. When the operation completes (`op_done`), the five IEEE flags reported by the datapath are merged into the current-exception field. That field is then matched against the trap-enable mask. A match records an IEEE trap type and pulses `trap_pulse`. Without a match, the new flags are ORed into the accrued field.

The arithmetic itself is outside this block. The status word is kept in a register, and `stat_out` shows its current value. Status layout: current-exception bits 4:0, accrued bits 9:5, trap type bits 16:14, trap-enable mask bits 27:23. Within each five-bit field, bit 0 is inexact, bit 1 divide-by-zero, bit 2 underflow, bit 3 overflow and bit 4 invalid. Every other bit passes through untouched.

Top module: `fpu_exc_ctrl`

## Requirements
- R1: After reset, `stat_out` is 0 and `trap_pulse` is 0.
- R2: A cycle with `op_start` high and `op_done` low loads the register from `stat_in`, with bits 4:0 and 16:14 forced to 0. The new value is visible on the next cycle.
- R3: `ieee_flags` bits map to these flags: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. On `op_done`, each raised flag sets the bit at the same position in current-exception bits 4:0, and bits that are already set stay set.
- R4: If, after the merge, current-exception bits 4:0 ANDed with mask bits 27:23 give a nonzero result, trap type bits 16:14 become 3'b001. `trap_pulse` is high in the cycle after `op_done`.
- R5: When a trap is taken, accrued bits 9:5 keep their previous value.
- R6: When flags are raised but none of them is enabled, accrued bits 9:5 become their old value ORed with the merged current-exception bits, and trap type stays 0.
- R7: `op_done` with all flags low leaves the status word unchanged and gives no trap pulse.
- R8: `trap_pulse` is high only in a cycle that directly follows an `op_done` cycle. A single `op_done` gives a pulse exactly one cycle wide.
- R9: When `op_start` and `op_done` are high in the same cycle, the clearing of R2 is applied to `stat_in` first, and the flags are then merged into that cleared value.
- R10: With `op_start` and `op_done` both low, the status word holds and `trap_pulse` is 0.
- R11: Bits outside the four fields (31:28, 22:17, 13:10) pass from `stat_in` on a start and are never changed by a completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | An FP operation begins; load and clear the status word |
| op_done | input | 1 | An FP operation finished; merge the flags |
| ieee_flags | input | 5 | Raised IEEE flags (4 invalid, 3 overflow, 2 underflow, 1 div-by-zero, 0 inexact) |
| stat_in | input | 32 | Status word sampled on `op_start` |
| stat_out | output | 32 | Registered status word |
| trap_pulse | output | 1 | One-cycle trap request |

## Verification
The bench builds the block with its default layout: a 32-bit word, five flag bits, current-exception field at bit 0, accrued field at bit 5, trap type at bit 14 and enable mask at bit 23. With this layout, the full status word can be driven through `stat_in` and compared bit for bit. This covers the pass-through bits that sit between the fields, and it makes the 23-place mask alignment and the 5-place accrual shift directly observable. Directed scenarios cover the trap path, the accumulate path, the empty flag set, start and done arriving together, and back-to-back completions that OR into an uncleared current-exception field.

// File: rtl/fexc_pkg.sv
package fexc_pkg;

    // Status word geometry
    localparam int STAT_W   = 32;
    localparam int FLAG_W   = 5;
    localparam int FTT_W    = 3;

    // Default field placement inside the status word
    localparam int CEXC_POS = 0;
    localparam int AEXC_POS = 5;
    localparam int FTT_POS  = 14;
    localparam int TEM_POS  = 23;

    // Trap type code meaning "IEEE exception"
    localparam int FTT_IEEE_CODE = 1;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              trap;
    } fexc_state_t;

endpackage

// File: rtl/fexc_flag_merge.sv
module fexc_flag_merge #(
    parameter int FLAG_W = fexc_pkg::FLAG_W
) (
    input  logic [FLAG_W-1:0] cexc_old,
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] tem_aligned,
    output logic [FLAG_W-1:0] cexc_new,
    output logic              any_flag,
    output logic              trap_hit
);

    logic [FLAG_W-1:0] hit_vec;

    // Per-flag merge and enable match
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        assign cexc_new[i] = cexc_old[i] | flags[i];
        assign hit_vec[i]  = cexc_new[i] & tem_aligned[i];
    end

    assign any_flag = |flags;
    assign trap_hit = |hit_vec;

endmodule

// File: rtl/fexc_stat_next.sv
module fexc_stat_next #(
    parameter int STAT_W   = fexc_pkg::STAT_W,
    parameter int FLAG_W   = fexc_pkg::FLAG_W,
    parameter int FTT_W    = fexc_pkg::FTT_W,
    parameter int CEXC_POS = fexc_pkg::CEXC_POS,
    parameter int AEXC_POS = fexc_pkg::AEXC_POS,
    parameter int FTT_POS  = fexc_pkg::FTT_POS,
    parameter int TEM_POS  = fexc_pkg::TEM_POS,
    parameter int FTT_IEEE = fexc_pkg::FTT_IEEE_CODE
) (
    input  logic [STAT_W-1:0] stat_cur,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              op_start,
    input  logic              op_done,
    input  logic [FLAG_W-1:0] flags,
    output logic [STAT_W-1:0] stat_nxt,
    output logic              trap_nxt
);

    localparam logic [STAT_W-1:0] CEXC_MASK =
        {{(STAT_W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}} << CEXC_POS;
    localparam logic [STAT_W-1:0] FTT_MASK =
        {{(STAT_W-FTT_W){1'b0}}, {FTT_W{1'b1}}} << FTT_POS;
    localparam logic [STAT_W-1:0] CLR_MASK = CEXC_MASK | FTT_MASK;

    logic [STAT_W-1:0] base_d;
    logic [FLAG_W-1:0] base_cexc;
    logic [FLAG_W-1:0] base_tem;
    logic [FLAG_W-1:0] cexc_new;
    logic              any_flag;
    logic              trap_hit;

    // Start of operation: take the software view and clear per-op fields
    always_comb begin
        base_d = op_start ? (stat_in & ~CLR_MASK) : stat_cur;
    end

    assign base_cexc = base_d[CEXC_POS +: FLAG_W];
    assign base_tem  = base_d[TEM_POS +: FLAG_W];

    fexc_flag_merge #(
        .FLAG_W (FLAG_W)
    ) u_merge (
        .cexc_old    (base_cexc),
        .flags       (flags),
        .tem_aligned (base_tem),
        .cexc_new    (cexc_new),
        .any_flag    (any_flag),
        .trap_hit    (trap_hit)
    );

    // Completion: record flags, then trap or accumulate
    always_comb begin
        stat_nxt = base_d;
        trap_nxt = 1'b0;
        if (op_done && any_flag) begin
            stat_nxt[CEXC_POS +: FLAG_W] = cexc_new;
            if (trap_hit) begin
                stat_nxt[FTT_POS +: FTT_W] = FTT_W'(FTT_IEEE);
                trap_nxt = 1'b1;
            end else begin
                stat_nxt[AEXC_POS +: FLAG_W] = base_d[AEXC_POS +: FLAG_W] | cexc_new;
            end
        end
    end

endmodule

// File: rtl/fpu_exc_ctrl.sv
module fpu_exc_ctrl
    import fexc_pkg::*;
#(
    parameter int CEXC_LSB = fexc_pkg::CEXC_POS,
    parameter int AEXC_LSB = fexc_pkg::AEXC_POS,
    parameter int FTT_LSB  = fexc_pkg::FTT_POS,
    parameter int TEM_LSB  = fexc_pkg::TEM_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_done,
    input  logic [FLAG_W-1:0] ieee_flags,
    input  logic [STAT_W-1:0] stat_in,
    output logic [STAT_W-1:0] stat_out,
    output logic              trap_pulse
);

    fexc_state_t       state_d, state_q;
    logic [STAT_W-1:0] stat_nxt;
    logic              trap_nxt;

    fexc_stat_next #(
        .STAT_W   (STAT_W),
        .FLAG_W   (FLAG_W),
        .FTT_W    (FTT_W),
        .CEXC_POS (CEXC_LSB),
        .AEXC_POS (AEXC_LSB),
        .FTT_POS  (FTT_LSB),
        .TEM_POS  (TEM_LSB),
        .FTT_IEEE (FTT_IEEE_CODE)
    ) u_next (
        .stat_cur (state_q.stat),
        .stat_in  (stat_in),
        .op_start (op_start),
        .op_done  (op_done),
        .flags    (ieee_flags),
        .stat_nxt (stat_nxt),
        .trap_nxt (trap_nxt)
    );

    always_comb begin
        state_d      = state_q;
        state_d.stat = stat_nxt;
        state_d.trap = trap_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_out   = state_q.stat;
    assign trap_pulse = state_q.trap;

    // Start alone clears the per-operation fields
    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !op_done) |=>
            (stat_out[CEXC_LSB +: FLAG_W] == '0 && stat_out[FTT_LSB +: FTT_W] == '0));

    // Every raised flag is present in the current-exception field
    p_flags_recorded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_start) |=>
            ((stat_out[CEXC_LSB +: FLAG_W] & $past(ieee_flags)) == $past(ieee_flags)));

    p_trap_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (stat_out[FTT_LSB +: FTT_W] == FTT_W'(FTT_IEEE_CODE)));

    p_accrued_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pulse && !$past(op_start)) |->
            (stat_out[AEXC_LSB +: FLAG_W] == $past(stat_out[AEXC_LSB +: FLAG_W])));

    p_empty_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_start && ieee_flags == '0) |=> ($stable(stat_out) && !trap_pulse));

    p_pulse_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> $past(op_done));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_start && !op_done) |=> ($stable(stat_out) && !trap_pulse));

endmodule

// File: tb/sim_fpu_exc_ctrl.sv
module sim_fpu_exc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic        op_done = 1'b0;
    logic [4:0]  ieee_flags = '0;
    logic [31:0] stat_in = '0;
    logic [31:0] stat_out;
    logic        trap_pulse;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_stat;
    logic        exp_trap;

    always #4 clk = ~clk;   // 125 MHz

    fpu_exc_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_done    (op_done),
        .ieee_flags (ieee_flags),
        .stat_in    (stat_in),
        .stat_out   (stat_out),
        .trap_pulse (trap_pulse)
    );

    // Reference model built from the requirement text
    function automatic logic [31:0] ref_start(input logic [31:0] si);
        return si & ~32'h0001_C01F;
    endfunction

    function automatic logic [32:0] ref_done(input logic [31:0] s, input logic [4:0] f);
        logic [31:0] n;
        logic [4:0]  c;
        logic        t;
        n = s;
        t = 1'b0;
        if (f != 0) begin
            c = s[4:0] | f;
            n[4:0] = c;
            if ((c & s[27:23]) != 0) begin
                n[16:14] = 3'b001;
                t = 1'b1;
            end else begin
                n[9:5] = s[9:5] | c;
            end
        end
        return {t, n};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One clock with the given inputs, sampled 1 ns after the edge
    task automatic cyc(input logic s, input logic d, input logic [4:0] f, input logic [31:0] si);
        @(negedge clk);
        op_start = s; op_done = d; ieee_flags = f; stat_in = si;
        @(posedge clk);
        #1;
        op_start = 1'b0; op_done = 1'b0; ieee_flags = '0;
    endtask

    task automatic t_reset;
        chk("R1 stat", stat_out, 32'h0);
        chk("R1 trap", {31'b0, trap_pulse}, 32'h0);
    endtask

    task automatic t_start_clear;
        cyc(1, 0, 0, 32'hFFFF_FFFF);
        chk("R2/R11 start", stat_out, 32'hFFFE_3FE0);
        chk("R10 no pulse", {31'b0, trap_pulse}, 32'h0);
    endtask

    task automatic t_accumulate;
        logic [32:0] r;
        cyc(1, 0, 0, 32'h0000_0040);
        cyc(0, 1, 5'b10001, 32'h0);
        r = ref_done(32'h0000_0040, 5'b10001);
        chk("R3/R6 accumulate", stat_out, r[31:0]);
        chk("R6 literal", stat_out, 32'h0000_0271);
        chk("R6 no trap", {31'b0, trap_pulse}, 32'h0);
        // Second completion without a new start: current flags OR together
        exp_stat = stat_out;
        cyc(0, 1, 5'b00100, 32'h0);
        r = ref_done(exp_stat, 5'b00100);
        chk("R3 or-merge", stat_out, r[31:0]);
    endtask

    task automatic t_trap;
        cyc(1, 0, 0, 32'h0400_0020);
        cyc(0, 1, 5'b01000, 32'h0);
        chk("R4/R5 trap status", stat_out, 32'h0400_4028);
        chk("R4 trap pulse", {31'b0, trap_pulse}, 32'h1);
        cyc(0, 0, 0, 32'h0);
        chk("R8 pulse width", {31'b0, trap_pulse}, 32'h0);
        chk("R10 hold after trap", stat_out, 32'h0400_4028);
        cyc(1, 0, 0, stat_out);
        chk("R2 ftt cleared", stat_out, 32'h0400_0020);
    endtask

    task automatic t_disabled_flag;
        logic [32:0] r;
        cyc(1, 0, 0, 32'h0800_0000);
        cyc(0, 1, 5'b00001, 32'h0);
        r = ref_done(32'h0800_0000, 5'b00001);
        chk("R6 masked flag", stat_out, r[31:0]);
        chk("R6 masked no trap", {31'b0, trap_pulse}, {31'b0, r[32]});
    endtask

    task automatic t_empty;
        cyc(1, 0, 0, 32'hF7C0_3FE0);
        exp_stat = stat_out;
        cyc(0, 1, 5'b00000, 32'h0);
        chk("R7 unchanged", stat_out, exp_stat);
        chk("R7 no trap", {31'b0, trap_pulse}, 32'h0);
    endtask

    task automatic t_combined;
        cyc(1, 1, 5'b00010, 32'h0101_C01F);
        chk("R9 combined", stat_out, 32'h0100_4002);
        chk("R9 pulse", {31'b0, trap_pulse}, 32'h1);
    endtask

    task automatic t_passthrough;
        logic [32:0] r;
        cyc(1, 0, 0, 32'hF07E_3C00);
        cyc(0, 1, 5'b11111, 32'h0);
        r = ref_done(32'hF07E_3C00, 5'b11111);
        chk("R11 outside bits", stat_out & 32'hF07E_3C00, 32'hF07E_3C00);
        chk("R6 all flags", stat_out, r[31:0]);
    endtask

    task automatic t_idle;
        exp_stat = stat_out;
        for (int i = 0; i < 5; i++) begin
            cyc(0, 0, 5'b11111, 32'hDEAD_BEEF);
        end
        chk("R10 idle hold", stat_out, exp_stat);
        chk("R10 idle trap", {31'b0, trap_pulse}, 32'h0);
    endtask

    initial begin : watchdog
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_trap = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_start_clear();
        t_accumulate();
        t_trap();
        t_disabled_flag();
        t_empty();
        t_combined();
        t_passthrough();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule